// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Decoder Model

This block is a synthesizable, cycle-based model of how a byte-wide one-time-programmable memory behaves at its control pins. A programmer or memory controller under development can use it as a stand-in device. The model is built from three inputs:

- the chip-enable and output-enable strobes, both active low;
- a flag meaning the programming supply is raised;
- a flag meaning address line 9 carries the identification high voltage.

From these it works out the operating mode: read, output disable, standby, program, program inhibit or identification. It then either drives a byte or lets the bus float. Analog levels and nanosecond timing are not modelled. The address-to-data delay, the enable-to-drive delay and the release-to-float delay are all counted in clock cycles.

Programming only clears bits. A write stores the old byte ANDed with the input byte. The write commits when chip enable rises at the end of a low pulse that was long enough. In identification mode the block returns a maker byte or a device byte, selected by address bit 0.

Two state machines carry the behaviour. The read-path machine has four states:

- RD_FLOAT: not driving.
- RD_SETTLE: read mode is present and the enable delay is running.
- RD_DRIVE: the block drives the bus.
- RD_RELEASE: read mode has ended but the float delay is still running.

Its transitions are:

- FLOAT→SETTLE on read. If the enable delay is at most 1, it goes FLOAT→DRIVE directly.
- SETTLE→DRIVE when the delay count is reached.
- SETTLE→FLOAT if read is lost.
- DRIVE→RELEASE when read ends. If the float delay is at most 1, it goes DRIVE→FLOAT directly.
- RELEASE→DRIVE if read returns.
- RELEASE→FLOAT when the float count is reached.

The program machine has two states, PG_IDLE and PG_PULSE. Its transitions are:

- IDLE→PULSE on entering program mode.
- PULSE→IDLE on commit, when chip enable rises with the supply still high.
- PULSE→IDLE on abort, when the supply drops.

Top module: `otp_mode_model`

## Requirements
- R1: While reset is low and after reset, every cell reads 8'hFF, dout_en is 0, dout is 0 and standby is 1.
- R2: With ce_n=0, oe_n=0, vpp_hi=0 and a9_hv=0, the block drives the cell selected by addr[STORE_AW-1:0]; upper address bits alias. Whenever dout_en is 0, dout is 0.
- R3: dout_en rises at the DLY_OE-th consecutive rising edge that samples read mode.
- R4: dout_en falls at the DLY_DF-th consecutive rising edge that samples a mode other than read. Output disable (ce_n=0, oe_n=1, vpp_hi=0) does not drive.
- R5: standby equals the value of ce_n sampled at the previous rising edge. With ce_n=1 the bus floats whatever the other inputs are.
- R6: After an address change, dout shows the new byte DLY_ACC rising edges later. Until then it holds the earlier byte.
- R7: With vpp_hi=1 the block never drives. With vpp_hi=1 and ce_n=1 (inhibit), no cell changes.
- R8: In read mode with a9_hv=1, when all address bits other than bit 0 and bit 9 are 0, dout is 8'h1E if addr[0]=0 and 8'h0D if addr[0]=1.
- R9: In read mode with a9_hv=1, when any address bit other than bit 0 and bit 9 is 1, dout is 8'hFF.
- R10: A program pulse commits when ce_n rises with vpp_hi=1 after at least PGM_MIN rising edges have sampled ce_n=0 and vpp_hi=1. The cell becomes old AND din, so no bit goes from 0 to 1.
- R11: A pulse of fewer than PGM_MIN edges leaves the cell unchanged.
- R12: If vpp_hi falls while ce_n is still low, the pulse is aborted and no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; erases all cells |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply is raised |
| a9_hv | input | 1 | Address line 9 is at identification voltage |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Output byte, 0 when not driven |
| dout_en | output | 1 | Output driver enable |
| standby | output | 1 | Chip is deselected (registered) |

## Verification
The hardest situation to reach from the ports is a programming pulse that ends by abort rather than by commit. The programming supply has to fall while chip enable is still low and output enable stays high, so that the block never passes through read mode. Only then can the following read show that the cell kept its old value. The stimulus builds this in sequence: first it raises the supply with chip enable high, then it holds chip enable low for longer than the minimum pulse, then it drops the supply, and only after that does it release chip enable. The exact-edge checks of the enable, float and address delays need the block to start in a known float or drive state. The bench therefore parks it in standby, or holds a stable read, for longer than the longest delay before each measurement.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_INHIBIT,
        MODE_PROGRAM,
        MODE_DISABLE,
        MODE_READ
    } mode_e;

    typedef enum logic [1:0] {
        RD_FLOAT,
        RD_SETTLE,
        RD_DRIVE,
        RD_RELEASE
    } rd_state_e;

    typedef enum logic {
        PG_IDLE,
        PG_PULSE
    } pg_state_e;

    localparam logic [7:0] ID_MAKER  = 8'h1E;
    localparam logic [7:0] ID_DEVICE = 8'h0D;
    localparam logic [7:0] ERASED    = 8'hFF;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    output mode_e mode
);

    // Chip enable dominates, then the supply flag, then output enable.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vpp_hi) begin
            mode = MODE_PROGRAM;
        end else if (oe_n) begin
            mode = MODE_DISABLE;
        end else begin
            mode = MODE_READ;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STORE_AW = 8,
    parameter int PGM_MIN  = 25000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  mode_e               mode,
    input  logic [STORE_AW-1:0] idx,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   rd_data,
    output logic                commit
);

    localparam int DEPTH = 1 << STORE_AW;
    localparam int CNT_W = $clog2(PGM_MIN + 1);

    logic [DATA_W-1:0]   cells [DEPTH];
    pg_state_e           pg_state, pg_next;
    logic [CNT_W-1:0]    pcnt;
    logic [STORE_AW-1:0] lat_idx;
    logic [DATA_W-1:0]   lat_data;

    // State register, pulse counter and latched write target.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_state <= PG_IDLE;
            pcnt     <= '0;
            lat_idx  <= '0;
            lat_data <= '0;
        end else begin
            pg_state <= pg_next;
            if (mode == MODE_PROGRAM) begin
                lat_idx  <= idx;
                lat_data <= din;
            end
            unique case (pg_state)
                PG_IDLE:  pcnt <= CNT_W'(1);
                PG_PULSE: if (mode == MODE_PROGRAM && pcnt < CNT_W'(PGM_MIN))
                              pcnt <= pcnt + CNT_W'(1);
            endcase
        end
    end

    // Transitions: IDLE->PULSE on program; PULSE->IDLE on commit or abort.
    always_comb begin
        pg_next = pg_state;
        unique case (pg_state)
            PG_IDLE:  if (mode == MODE_PROGRAM) pg_next = PG_PULSE;
            PG_PULSE: if (mode != MODE_PROGRAM) pg_next = PG_IDLE;
        endcase
    end

    // Commit only when chip enable rose with the supply still raised (R10, R11, R12).
    always_comb begin
        commit = (pg_state == PG_PULSE) && (mode == MODE_INHIBIT) &&
                 (pcnt >= CNT_W'(PGM_MIN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= DATA_W'(ERASED);
        end else if (commit) begin
            cells[lat_idx] <= cells[lat_idx] & lat_data;
        end
    end

    assign rd_data = cells[idx];

endmodule

// File: rtl/otp_read_path.sv
module otp_read_path
    import otp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DLY_ACC = 23,
    parameter int DLY_OE  = 13,
    parameter int DLY_DF  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [DATA_W-1:0] lookup,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int MAXD = (DLY_OE > DLY_DF) ? DLY_OE : DLY_DF;
    localparam int CW   = $clog2(MAXD + 1);

    rd_state_e     st, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          rd;

    // Address-to-data delay line, one register per cycle (R6).
    for (genvar g = 0; g < DLY_ACC; g++) begin : g_stage
        logic [DATA_W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= lookup;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign rd = (mode == MODE_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RD_FLOAT;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = st;
        cnt_nxt = cnt;
        unique case (st)
            RD_FLOAT: if (rd) begin
                cnt_nxt = CW'(1);
                nxt     = (DLY_OE <= 1) ? RD_DRIVE : RD_SETTLE;
            end
            RD_SETTLE: if (!rd) begin
                nxt = RD_FLOAT;
            end else begin
                cnt_nxt = cnt + CW'(1);
                if ((cnt + CW'(1)) >= CW'(DLY_OE)) nxt = RD_DRIVE;
            end
            RD_DRIVE: if (!rd) begin
                cnt_nxt = CW'(1);
                nxt     = (DLY_DF <= 1) ? RD_FLOAT : RD_RELEASE;
            end
            RD_RELEASE: if (rd) begin
                nxt = RD_DRIVE;
            end else begin
                cnt_nxt = cnt + CW'(1);
                if ((cnt + CW'(1)) >= CW'(DLY_DF)) nxt = RD_FLOAT;
            end
        endcase
    end

    // Output process.
    always_comb begin
        dout_en = (st == RD_DRIVE) || (st == RD_RELEASE);
        dout    = dout_en ? g_stage[DLY_ACC-1].q : '0;
    end

endmodule

// File: rtl/otp_mode_model.sv
module otp_mode_model
    import otp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int STORE_AW = 8,
    parameter int DLY_ACC  = 23,
    parameter int DLY_OE   = 13,
    parameter int DLY_DF   = 10,
    parameter int PGM_MIN  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              standby
);

    localparam logic [ADDR_W-1:0] ID_CARE = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

    mode_e             mode;
    logic [DATA_W-1:0] cell_byte;
    logic [DATA_W-1:0] lookup;
    logic              pg_commit;

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .mode   (mode)
    );

    otp_cell_array #(
        .DATA_W   (DATA_W),
        .STORE_AW (STORE_AW),
        .PGM_MIN  (PGM_MIN)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .idx     (addr[STORE_AW-1:0]),
        .din     (din),
        .rd_data (cell_byte),
        .commit  (pg_commit)
    );

    // Identification bytes replace the array when the high-voltage flag is set (R8, R9).
    always_comb begin
        if (a9_hv) begin
            if ((addr & ID_CARE) == '0)
                lookup = addr[0] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);
            else
                lookup = DATA_W'(ERASED);
        end else begin
            lookup = cell_byte;
        end
    end

    otp_read_path #(
        .DATA_W  (DATA_W),
        .DLY_ACC (DLY_ACC),
        .DLY_OE  (DLY_OE),
        .DLY_DF  (DLY_DF)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .lookup  (lookup),
        .dout    (dout),
        .dout_en (dout_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) standby <= 1'b1;
        else        standby <= ce_n;
    end

endmodule

// File: rtl/otp_mode_model_chk.sv
module otp_mode_model_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic vpp_hi,
    input logic dout_en,
    input logic standby,
    input logic commit
);

    AST_EN_RISE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(!ce_n && !oe_n && !vpp_hi)); // R3

    AST_EN_FALL_OUT_OF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_en) |-> $past(ce_n || oe_n || vpp_hi)); // R4

    AST_STANDBY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(ce_n)); // R5

    AST_COMMIT_AT_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (ce_n && vpp_hi && $past(!ce_n))); // R10

    AST_DRIVE_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !ce_n && !oe_n && !vpp_hi) |=> dout_en); // R4

endmodule

bind otp_mode_model otp_mode_model_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .dout_en (dout_en),
    .standby (standby),
    .commit  (pg_commit)
);

// File: tb/otp_mode_model_tb.sv
`timescale 1ns/1ps
module otp_mode_model_tb;

    localparam int ACC  = 23;
    localparam int OE   = 13;
    localparam int DF   = 10;
    localparam int PGM  = 25;
    localparam int SETL = 40;

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic        vpp;
        logic        a9;
        logic [15:0] addr;
        logic        en;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0034, 1'b1, 8'hFF},  // R2 read
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0034, 1'b0, 8'h00},  // R4 disable
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0034, 1'b0, 8'h00},  // R5 standby
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0034, 1'b0, 8'h00},  // R7 program
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'h0034, 1'b0, 8'h00},  // R7 inhibit
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0200, 1'b1, 8'h1E},  // R8 maker
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b1, 8'h0D},  // R8 device
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 8'h1E},  // R8 bit9 ignored
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0203, 1'b1, 8'hFF},  // R9
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h8001, 1'b1, 8'hFF}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        vpp_hi = 1'b0;
    logic        a9_hv = 1'b0;
    logic [7:0]  din = 8'hFF;
    logic [7:0]  dout;
    logic        dout_en;
    logic        standby;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    otp_mode_model #(
        .DLY_ACC (ACC),
        .DLY_OE  (OE),
        .DLY_DF  (DF),
        .PGM_MIN (PGM)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .a9_hv   (a9_hv),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en),
        .standby (standby)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic v, input logic a9,
                         input logic [15:0] a);
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = a9; addr = a;
    endtask

    task automatic read_at(input logic [15:0] a);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, a);
        repeat (SETL) @(negedge clk);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, a);
        din = d;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        vpp_hi = 1'b0;
        din = 8'hFF;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dout_en", {7'b0, dout_en}, 8'h00);
        chk("R1 dout", dout, 8'h00);
        chk("R1 standby", {7'b0, standby}, 8'h01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ce_n, VEC[i].oe_n, VEC[i].vpp, VEC[i].a9, VEC[i].addr);
            repeat (SETL) @(negedge clk);
            chk($sformatf("R2-table vec%0d en", i), {7'b0, dout_en}, {7'b0, VEC[i].en});
            chk($sformatf("R8-table vec%0d data", i), dout, VEC[i].data);
            chk($sformatf("R5 vec%0d standby", i), {7'b0, standby}, {7'b0, VEC[i].ce_n});
        end

        // R10: programming clears bits only
        prog(16'h0012, 8'h5A, PGM);
        read_at(16'h0012);
        chk("R10 first write", dout, 8'h5A);
        prog(16'h0012, 8'h0F, PGM);
        read_at(16'h0012);
        chk("R10 and-merge", dout, 8'h0A);
        prog(16'h0012, 8'hFF, PGM);
        read_at(16'h0012);
        chk("R10 no bit set", dout, 8'h0A);

        // R11: short pulse
        prog(16'h0012, 8'h00, PGM - 1);
        read_at(16'h0012);
        chk("R11 short pulse", dout, 8'h0A);

        // R12: supply drops before chip enable rises
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 16'h0012);
        din = 8'h00;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (PGM + 3) @(negedge clk);
        vpp_hi = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        read_at(16'h0012);
        chk("R12 abort", dout, 8'h0A);

        // R7: inhibit writes nothing
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 16'h0012);
        din = 8'h00;
        repeat (SETL) @(negedge clk);
        chk("R7 inhibit float", {7'b0, dout_en}, 8'h00);
        vpp_hi = 1'b0;
        din = 8'hFF;
        read_at(16'h0012);
        chk("R7 inhibit no write", dout, 8'h0A);

        // R2: aliasing of upper address bits
        read_at(16'h0112);
        chk("R2 alias", dout, 8'h0A);

        // R3: enable delay, starting from float
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0034);
        repeat (SETL) @(negedge clk);
        chk("R5 standby high", {7'b0, standby}, 8'h01);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0034);
        repeat (OE - 1) @(posedge clk);
        @(negedge clk);
        chk("R3 before delay", {7'b0, dout_en}, 8'h00);
        @(negedge clk);
        chk("R3 at delay", {7'b0, dout_en}, 8'h01);
        chk("R5 standby low", {7'b0, standby}, 8'h00);

        // R6: address to data delay
        repeat (SETL) @(negedge clk);
        addr = 16'h0012;
        repeat (ACC - 1) @(posedge clk);
        @(negedge clk);
        chk("R6 old byte held", dout, 8'hFF);
        @(negedge clk);
        chk("R6 new byte", dout, 8'h0A);

        // R4: float delay
        repeat (4) @(negedge clk);
        oe_n = 1'b1;
        repeat (DF - 1) @(posedge clk);
        @(negedge clk);
        chk("R4 still driving", {7'b0, dout_en}, 8'h01);
        @(negedge clk);
        chk("R4 floated", {7'b0, dout_en}, 8'h00);
        chk("R2 zero when off", dout, 8'h00);

        // R5: one-edge standby latency
        ce_n = 1'b1;
        @(negedge clk);
        chk("R5 standby latency", {7'b0, standby}, 8'h01);

        // R1: reset erases cells
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_at(16'h0012);
        chk("R1 erased", dout, 8'hFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule